// File: doc/BRIEF.md
# Banked Dual-Port Display Refresh Memory

This block stores a monochrome picture of 65 rows by 102 columns and feeds it, one row at a time, to the column drivers of a multiplexed LCD. A host writes and reads the picture through a byte-wide port. Each byte covers eight vertically stacked pixels of one column inside a bank. Banks 0 to 7 are a full eight rows tall. Bank 8 holds the single last row. The column address is the column output number, so column pointer value X lands on `col_data[X]`.

A separate scan side steps through the rows once per pulse of a row-rate enable. For each row it latches the whole 102-bit row vector, together with a one-hot row select and a frame marker. Host traffic never stalls or alters the scan. A pixel written while its row is on display shows up the next time that row is loaded. Row r lives in bank r/8 at bit position r%8 of the byte.

Top module: `lcd_fb_scan`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the outputs take these values: row_idx = 0, row_sel = 1 (only bit 0 set), col_data = 0, frame_start = 0, host_rvalid = 0 and host_rdata = 0. The host pointer is set to bank 0, column 0. The contents of the pixel storage are not defined by reset.
- R2: When host_set is high at a clock edge, the pointer is loaded from host_bank and host_col, but only if host_bank ≤ 8 and host_col ≤ 101. If either value is out of range, the strobe is ignored and the pointer keeps its previous value.
- R3: When host_wr is high at a clock edge, bit i of host_wdata (i = 0..7) is stored as the pixel at row 8·bank+i of the pointed column. For bank 8, only bit 0 is stored, at row 64, and bits 7:1 are discarded.
- R4: When host_rd is high at a clock edge, host_rvalid is high for exactly the following cycle. In that cycle, host_rdata bit i holds the pixel at row 8·bank+i of the pointed column. For bank 8, bits 7:1 read as 0. host_rdata keeps its value until the next read, and host_rvalid is low in every cycle that does not follow a read.
- R5: Each accepted write or read moves the column pointer on by one, wrapping from 101 to 0. The bank pointer is left unchanged.
- R6: When several host strobes are high in one cycle, host_set wins over host_wr, and host_wr wins over host_rd. The losing strobes have no effect: no store, no pointer step, no read response.
- R7: row_idx advances by one at each clock edge where row_tick is high, wrapping from 64 to 0. At all other edges it holds its value.
- R8: row_sel always has exactly one bit set, the bit at position row_idx. col_data[c] is the pixel at (row_idx, c) as it was stored when the row was loaded. col_data, row_sel and row_idx change only at edges where row_tick is high.
- R9: frame_start is high for exactly the one cycle that follows a row_tick edge which moved row_idx to 0. It is low at all other times.
- R10: If a host write and a row_tick that loads the same row fall on the same edge, col_data shows the value from before the write. The new value appears when that row is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_set | input | 1 | Load the pointer from host_bank/host_col |
| host_bank | input | 4 | Bank for a pointer load |
| host_col | input | 7 | Column for a pointer load |
| host_wr | input | 1 | Store host_wdata at the pointer |
| host_wdata | input | 8 | Write byte; bit i goes to row 8·bank+i |
| host_rd | input | 1 | Read the byte at the pointer |
| host_rdata | output | 8 | Last read byte |
| host_rvalid | output | 1 | High in the cycle after a read is accepted |
| row_tick | input | 1 | Row-rate enable; each pulse advances the scan |
| row_idx | output | 7 | Row currently presented |
| row_sel | output | 65 | One-hot row select |
| col_data | output | 102 | Pixels of the presented row, one per column |
| frame_start | output | 1 | Marks the first row of a frame |

## Verification
Every cycle, the assertions check the scan-side rules: row_sel is one-hot and agrees with row_idx, the row index and the column vector stay still between ticks, the wrap from row 64 to row 0 raises frame_start, and host_rvalid follows accepted reads. Some rules cannot be checked that way. Whether the right pixels reach col_data, the bank-8 masking, ignored pointer loads, strobe priority and the old-value rule for a write that lands on the same edge as a tick all need the stored picture. They are shown only by the bench. It fills the whole frame, reads it back, scans it and compares every output against its own pixel model.

// File: rtl/lcd_fb_pkg.sv
package lcd_fb_pkg;

    // Host operation chosen for the current cycle after priority resolution.
    typedef enum logic [1:0] {
        HOP_NONE = 2'd0,
        HOP_SET  = 2'd1,
        HOP_WR   = 2'd2,
        HOP_RD   = 2'd3
    } host_op_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/lcd_fb_host_port.sv
module lcd_fb_host_port
    import lcd_fb_pkg::*;
#(
    parameter int NBANKS = 9,
    parameter int COLS   = 102,
    parameter int BKW    = 4,
    parameter int CW     = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_i,
    input  logic [BKW-1:0] bank_i,
    input  logic [CW-1:0]  col_i,
    input  logic           wr_i,
    input  logic           rd_i,
    output host_op_e       op_o,
    output logic [BKW-1:0] ptr_bank_o,
    output logic [CW-1:0]  ptr_col_o
);

    typedef struct packed {
        logic [BKW-1:0] bank;
        logic [CW-1:0]  col;
    } ptr_t;

    ptr_t     ptr_d, ptr_q;
    host_op_e op;
    logic     load_ok;

    always_comb begin
        if (set_i)      op = HOP_SET;
        else if (wr_i)  op = HOP_WR;
        else if (rd_i)  op = HOP_RD;
        else            op = HOP_NONE;

        load_ok = (bank_i <= BKW'(NBANKS - 1)) && (col_i <= CW'(COLS - 1));

        ptr_d = ptr_q;
        case (op)
            HOP_SET: begin
                if (load_ok) begin
                    ptr_d.bank = bank_i;
                    ptr_d.col  = col_i;
                end
            end
            HOP_WR, HOP_RD: begin
                if (ptr_q.col == CW'(COLS - 1)) ptr_d.col = '0;
                else                            ptr_d.col = ptr_q.col + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign op_o       = op;
    assign ptr_bank_o = ptr_q.bank;
    assign ptr_col_o  = ptr_q.col;

endmodule

// File: rtl/lcd_fb_array.sv
module lcd_fb_array
    import lcd_fb_pkg::*;
#(
    parameter int ROWS   = 65,
    parameter int COLS   = 102,
    parameter int BANK_W = 8,
    parameter int BKW    = 4,
    parameter int CW     = 7,
    parameter int RW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  host_op_e          op_i,
    input  logic [BKW-1:0]    bank_i,
    input  logic [CW-1:0]     col_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] rdata_o,
    output logic              rvalid_o,
    input  logic [RW-1:0]     scan_row_i,
    output logic [COLS-1:0]   scan_vec_o
);

    typedef struct packed {
        logic [BANK_W-1:0] rdata;
        logic              rvalid;
    } rd_t;

    logic [COLS-1:0]   mem [ROWS];
    logic [RW-1:0]     lane_row [BANK_W];
    logic              lane_ok  [BANK_W];
    logic [BANK_W-1:0] gather;
    rd_t               rd_d, rd_q;

    // Map each byte lane to its physical row; lanes past the last row are dead.
    always_comb begin
        for (int i = 0; i < BANK_W; i++) begin
            lane_ok[i]  = (int'(bank_i) * BANK_W + i) < ROWS;
            lane_row[i] = RW'(int'(bank_i) * BANK_W + i);
        end
    end

    always_comb begin
        for (int i = 0; i < BANK_W; i++) begin
            gather[i] = lane_ok[i] ? mem[lane_row[i]][col_i] : 1'b0;
        end
    end

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = 1'b0;
        if (op_i == HOP_RD) begin
            rd_d.rdata  = gather;
            rd_d.rvalid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    // Storage has no reset; a write lands after the scan side has sampled.
    always_ff @(posedge clk) begin
        if (op_i == HOP_WR) begin
            for (int i = 0; i < BANK_W; i++) begin
                if (lane_ok[i]) mem[lane_row[i]][col_i] <= wdata_i[i];
            end
        end
    end

    assign scan_vec_o = mem[scan_row_i];
    assign rdata_o    = rd_q.rdata;
    assign rvalid_o   = rd_q.rvalid;

endmodule

// File: rtl/lcd_fb_scanner.sv
module lcd_fb_scanner #(
    parameter int ROWS = 65,
    parameter int COLS = 102,
    parameter int RW   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [COLS-1:0] scan_vec_i,
    output logic [RW-1:0]   scan_row_o,
    output logic [RW-1:0]   row_o,
    output logic [ROWS-1:0] sel_o,
    output logic [COLS-1:0] cols_o,
    output logic            fs_o
);

    typedef struct packed {
        logic [RW-1:0]   row;
        logic [ROWS-1:0] sel;
        logic [COLS-1:0] cols;
        logic            fs;
    } scan_t;

    scan_t         s_d, s_q;
    logic [RW-1:0] row_next;

    always_comb begin
        if (s_q.row == RW'(ROWS - 1)) row_next = '0;
        else                          row_next = s_q.row + 1'b1;

        s_d    = s_q;
        s_d.fs = 1'b0;
        if (tick_i) begin
            s_d.row  = row_next;
            s_d.sel  = {s_q.sel[ROWS-2:0], s_q.sel[ROWS-1]};
            s_d.cols = scan_vec_i;
            s_d.fs   = (row_next == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sel  <= ROWS'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign scan_row_o = row_next;
    assign row_o      = s_q.row;
    assign sel_o      = s_q.sel;
    assign cols_o     = s_q.cols;
    assign fs_o       = s_q.fs;

endmodule

// File: rtl/lcd_fb_scan.sv
module lcd_fb_scan
    import lcd_fb_pkg::*;
#(
    parameter  int ROWS   = 65,
    parameter  int COLS   = 102,
    parameter  int BANK_W = 8,
    localparam int NBANKS = ceil_div(ROWS, BANK_W),
    localparam int BKW    = $clog2(NBANKS),
    localparam int CW     = $clog2(COLS),
    localparam int RW     = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_set,
    input  logic [BKW-1:0]    host_bank,
    input  logic [CW-1:0]     host_col,
    input  logic              host_wr,
    input  logic [BANK_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [BANK_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              row_tick,
    output logic [RW-1:0]     row_idx,
    output logic [ROWS-1:0]   row_sel,
    output logic [COLS-1:0]   col_data,
    output logic              frame_start
);

    host_op_e        op;
    logic [BKW-1:0]  ptr_bank;
    logic [CW-1:0]   ptr_col;
    logic [RW-1:0]   scan_row;
    logic [COLS-1:0] scan_vec;

    lcd_fb_host_port #(
        .NBANKS(NBANKS), .COLS(COLS), .BKW(BKW), .CW(CW)
    ) u_host (
        .clk(clk), .rst_n(rst_n),
        .set_i(host_set), .bank_i(host_bank), .col_i(host_col),
        .wr_i(host_wr), .rd_i(host_rd),
        .op_o(op), .ptr_bank_o(ptr_bank), .ptr_col_o(ptr_col)
    );

    lcd_fb_array #(
        .ROWS(ROWS), .COLS(COLS), .BANK_W(BANK_W), .BKW(BKW), .CW(CW), .RW(RW)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .op_i(op), .bank_i(ptr_bank), .col_i(ptr_col), .wdata_i(host_wdata),
        .rdata_o(host_rdata), .rvalid_o(host_rvalid),
        .scan_row_i(scan_row), .scan_vec_o(scan_vec)
    );

    lcd_fb_scanner #(
        .ROWS(ROWS), .COLS(COLS), .RW(RW)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .tick_i(row_tick), .scan_vec_i(scan_vec),
        .scan_row_o(scan_row), .row_o(row_idx), .sel_o(row_sel),
        .cols_o(col_data), .fs_o(frame_start)
    );

endmodule

// File: rtl/lcd_fb_scan_chk.sv
module lcd_fb_scan_chk #(
    parameter int ROWS   = 65,
    parameter int COLS   = 102,
    parameter int BANK_W = 8,
    parameter int BKW    = 4,
    parameter int CW     = 7,
    parameter int RW     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_set,
    input logic              host_wr,
    input logic              host_rd,
    input logic              host_rvalid,
    input logic              row_tick,
    input logic [RW-1:0]     row_idx,
    input logic [ROWS-1:0]   row_sel,
    input logic [COLS-1:0]   col_data,
    input logic              frame_start
);

    a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_sel) == 1);

    a_r8_sel_matches_row: assert property (@(posedge clk) disable iff (!rst_n)
        row_sel[row_idx] == 1'b1);

    a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !row_tick |=> $stable(col_data) && $stable(row_idx) && $stable(row_sel));

    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (row_tick && row_idx == RW'(ROWS - 1)) |=> (row_idx == '0));

    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (row_tick && row_idx != RW'(ROWS - 1)) |=> (row_idx == $past(row_idx) + 1'b1));

    a_r9_frame_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (row_tick && row_idx == RW'(ROWS - 1)) |=> frame_start);

    a_r9_frame_only_row0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (row_idx == '0));

    a_r9_frame_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !row_tick |=> !frame_start);

    a_r4_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && !host_set) |=> host_rvalid);

    a_r6_rvalid_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && !host_wr && !host_set) |=> !host_rvalid);

endmodule

bind lcd_fb_scan lcd_fb_scan_chk #(
    .ROWS(ROWS), .COLS(COLS), .BANK_W(BANK_W), .BKW(BKW), .CW(CW), .RW(RW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_set(host_set), .host_wr(host_wr),
    .host_rd(host_rd), .host_rvalid(host_rvalid), .row_tick(row_tick),
    .row_idx(row_idx), .row_sel(row_sel), .col_data(col_data),
    .frame_start(frame_start)
);

// File: tb/lcd_fb_scan_bench.sv
module lcd_fb_scan_bench;

    localparam int NR = 65;
    localparam int NC = 102;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_set = 1'b0, in_wr = 1'b0, in_rd = 1'b0, in_tick = 1'b0;
    logic [3:0]   in_bank = '0;
    logic [6:0]   in_col = '0;
    logic [7:0]   in_wdata = '0;
    logic [7:0]   host_rdata;
    logic         host_rvalid;
    logic [6:0]   row_idx;
    logic [64:0]  row_sel;
    logic [101:0] col_data;
    logic         frame_start;

    always #5 clk = ~clk;

    lcd_fb_scan u_lcd_fb_scan (
        .clk(clk), .rst_n(rst_n),
        .host_set(in_set), .host_bank(in_bank), .host_col(in_col),
        .host_wr(in_wr), .host_wdata(in_wdata), .host_rd(in_rd),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .row_tick(in_tick), .row_idx(row_idx), .row_sel(row_sel),
        .col_data(col_data), .frame_start(frame_start)
    );

    // Behavioural reference model
    bit           pix [NR][NC];
    int           m_bank, m_col, m_row;
    logic [7:0]   m_rdata;
    bit           m_rvalid, m_fs;
    logic [101:0] m_cols;

    int  errors = 0, checks = 0, cycles = 0;
    bit  done = 0;
    int  lfsr = 32'h1ACE;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [7:0] gather(input int b, input int c);
        logic [7:0] v = '0;
        for (int i = 0; i < 8; i++)
            if (b * 8 + i < NR) v[i] = pix[b * 8 + i][c];
        return v;
    endfunction

    task automatic model(input bit s, input int b, input int c, input bit w,
                         input int d, input bit r, input bit t);
        if (!rst_n) begin
            m_bank = 0; m_col = 0; m_row = 0; m_rdata = '0;
            m_rvalid = 0; m_fs = 0; m_cols = '0;
            return;
        end
        m_fs = 0;
        if (t) begin
            m_row = (m_row + 1) % NR;
            for (int k = 0; k < NC; k++) m_cols[k] = pix[m_row][k];
            m_fs = (m_row == 0);
        end
        m_rvalid = 0;
        if (s) begin
            if (b <= 8 && c <= 101) begin m_bank = b; m_col = c; end
        end else if (w) begin
            for (int i = 0; i < 8; i++)
                if (m_bank * 8 + i < NR) pix[m_bank * 8 + i][m_col] = d[i];
            m_col = (m_col + 1) % NC;
        end else if (r) begin
            m_rdata = gather(m_bank, m_col);
            m_rvalid = 1;
            m_col = (m_col + 1) % NC;
        end
    endtask

    task automatic compare();
        logic [64:0] es = 65'd1 << m_row;
        chk("R7 row_idx", 128'(row_idx), 128'(m_row));
        chk("R8 row_sel", 128'(row_sel), 128'(es));
        chk("R8 col_data", 128'(col_data), 128'(m_cols));
        chk("R9 frame_start", 128'(frame_start), 128'(m_fs));
        chk("R4 host_rvalid", 128'(host_rvalid), 128'(m_rvalid));
        chk("R4 host_rdata", 128'(host_rdata), 128'(m_rdata));
    endtask

    task automatic step(input bit s, input int b, input int c, input bit w,
                        input int d, input bit r, input bit t);
        in_set = s; in_bank = 4'(b); in_col = 7'(c);
        in_wr = w; in_wdata = 8'(d); in_rd = r; in_tick = t;
        @(posedge clk); #1;
        model(s, b, c, w, d, r, t);
        compare();
        in_set = 0; in_wr = 0; in_rd = 0; in_tick = 0;
    endtask

    function automatic int rnd();
        lfsr = (lfsr * 1103515245 + 12345) & 32'h7FFFFFFF;
        return (lfsr >> 8) & 255;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        logic [7:0] keep;
        bit         old_px;
        rst_n = 0;
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0);
        // R1: reset values
        chk("R1 row_idx", 128'(row_idx), 128'd0);
        chk("R1 row_sel", 128'(row_sel), 128'd1);
        chk("R1 col_data", 128'(col_data), 128'd0);
        chk("R1 frame_start", 128'(frame_start), 128'd0);
        chk("R1 rvalid", 128'(host_rvalid), 128'd0);
        rst_n = 1;
        step(0, 0, 0, 0, 0, 0, 0);

        // R3: fill the whole frame bytewise (bank 8 gets full random bytes)
        for (int b = 0; b < 9; b++) begin
            step(1, b, 0, 0, 0, 0, 0);
            for (int c = 0; c < NC; c++) step(0, 0, 0, 1, rnd(), 0, 0);
        end
        // R5: pointer wrapped to column 0 of bank 8; one more write lands there
        step(0, 0, 0, 1, 8'hFF, 0, 0);
        step(1, 8, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R3 bank8 bit0 only", 128'(host_rdata), 128'h01);

        // R5: read across the column wrap
        step(1, 3, 100, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 1, 0);
        chk("R5 wrap to col 0", 128'(host_rdata), 128'(gather(3, 0)));

        // R4: bank 8 high bits read as zero; full bytes from other banks
        step(1, 8, 5, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R4 bank8 upper bits", 128'(host_rdata[7:1]), 128'd0);
        step(1, 5, 42, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R4 bank5 col42", 128'(host_rdata), 128'(gather(5, 42)));
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R4 rvalid one cycle", 128'(host_rvalid), 128'd0);

        // R2: out-of-range loads are ignored (pointer stays at bank 5 col 43)
        step(1, 9, 5, 0, 0, 0, 0);
        step(1, 2, 102, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R2 ignored load", 128'(host_rdata), 128'(gather(5, 43)));

        // R6: set beats write and read
        keep = gather(1, 10);
        step(1, 1, 10, 1, 8'h5A, 1, 0);
        chk("R6 set wins no rvalid", 128'(host_rvalid), 128'd0);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R6 set wins no store", 128'(host_rdata), 128'(keep));
        // write beats read: store happens, no read response
        step(1, 1, 20, 0, 0, 0, 0);
        step(0, 0, 0, 1, 8'hC3, 1, 0);
        chk("R6 write wins no rvalid", 128'(host_rvalid), 128'd0);
        step(1, 1, 20, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R6 write stored", 128'(host_rdata), 128'hC3);

        // R7/R8/R9: scan more than two frames with a tick every cycle
        for (int k = 0; k < 140; k++) begin
            step(0, 0, 0, 0, 0, 0, 1);
            if (row_idx == 0) chk("R9 frame at row 0", 128'(frame_start), 128'd1);
        end
        // slower row rate with host traffic in between
        step(1, 4, 0, 0, 0, 0, 0);
        for (int k = 0; k < 90; k++)
            step(0, 0, 0, (k % 3) == 1, rnd(), (k % 3) == 2, (k % 3) == 0);

        // R10: write and tick to the same row on one edge
        while (row_idx != 19) step(0, 0, 0, 0, 0, 0, 1);
        step(1, 2, 7, 0, 0, 0, 0);
        old_px = pix[20][7];
        step(0, 0, 0, 1, old_px ? 8'h00 : 8'hFF, 0, 1);
        chk("R10 old value shown", 128'(col_data[7]), 128'(old_px));
        for (int k = 0; k < NR; k++) step(0, 0, 0, 0, 0, 0, 1);
        chk("R10 new value next frame", 128'(col_data[7]), 128'(!old_px));

        // R1: reset mid-scan returns to initial state
        rst_n = 0;
        step(0, 0, 0, 0, 0, 0, 1);
        rst_n = 1;
        chk("R1 reset mid-scan row", 128'(row_idx), 128'd0);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R1 pointer bank0 col0", 128'(host_rdata), 128'(gather(0, 0)));
        for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 0, 0, 1);

        finish_run();
    end

endmodule